// File: doc/BRIEF.md
# Tuning Command Bus Receiver

This block is a write-only serial bus slave for I2C that takes tuning and control words for a PLL frequency synthesizer. It oversamples the bus clock and data lines with a fast system clock, resynchronises and de-glitches them, and finds start and stop conditions. After a start it compares the first byte with a chip address. Two select inputs fix two bits of that address. If the address matches, the block acknowledges and then takes the data bytes that follow in pairs.

The top bit of the first byte of each pair is a function bit that chooses where the pair goes. When it is clear, the pair loads a 15-bit divide ratio: the upper seven bits come from the low seven bits of the first byte, and the lower eight bits come from the second byte. When it is set, the low seven bits of the first byte load a 7-bit control field and the low nibble of the second byte loads a 4-bit band field. A register changes only once its pair is complete, and each change comes with a one-cycle update strobe. A lone trailing byte is dropped. Bytes after the fourth data byte get no acknowledge and have no effect. The acknowledge is driven as an open-drain pull-down enable on the data line.

Top module: `tune_cmd_rx`

## Requirements
- R1: After reset the divide ratio output is 256, the control and band outputs are 0, all update strobes are low and the data-line pull-down enable is low.
- R2: The receiver acknowledges an address byte equal to binary 1100_0, then addr_sel_i[1], then addr_sel_i[0], then a 0 in the LSB (hex C0, C2, C4 or C6). It acknowledges by holding sda_oe_o high for the whole ninth bus clock.
- R3: An address byte that differs from the selected address, or one whose LSB (the read/write bit) is 1, gets no acknowledge. The receiver then acknowledges nothing and changes no output until the next start condition.
- R4: A data pair whose first byte has MSB 0 sets ratio_o to {first[6:0], second[7:0]} and pulses ratio_upd_o high for exactly one system clock cycle.
- R5: A data pair whose first byte has MSB 1 sets ctrl_o to first[6:0] and band_o to second[3:0], ignoring second[7:4]. It pulses ctrl_upd_o and band_upd_o together for one cycle.
- R6: A frame of four data bytes applies both pairs, frequency first or control first. Each pair gives its own strobe, and the two strobes never occur in the same cycle.
- R7: In a frame of three data bytes the third byte is acknowledged but changes no output.
- R8: The first four data bytes are acknowledged. The fifth and later data bytes of a frame are not acknowledged and change no output.
- R9: A stop or repeated start before the second byte of a pair is complete abandons that pair, and no output changes.
- R10: A pulse on the bus clock line shorter than FILT_LEN system cycles is ignored. It adds no bit to the byte being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel_i | input | 2 | Selects address bits 2 and 1 of the chip address |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low (acknowledge) |
| ratio_o | output | 15 | Programmable divide ratio |
| ratio_upd_o | output | 1 | One-cycle strobe when ratio_o is loaded |
| ctrl_o | output | 7 | Control field |
| ctrl_upd_o | output | 1 | One-cycle strobe when ctrl_o is loaded |
| band_o | output | 4 | Band select field |
| band_upd_o | output | 1 | One-cycle strobe when band_o is loaded |

## Verification
The hardest cases to reach are a pair cut short by a repeated start in the middle of a byte, and a clock glitch in the middle of a bit. Neither occurs in a well-formed frame. The bench's bus driver can stop a byte after a chosen number of bits and issue a new start at once. It can also drop the clock line low for two system cycles while the clock is high. After each of these, the bench sends a clean frame and checks that only that frame's values appear.

// File: rtl/tune_rx_pkg.sv
package tune_rx_pkg;
  localparam int BYTE_W   = 8;
  localparam int RATIO_W  = 15;
  localparam int CTRL_W   = 7;
  localparam int BAND_W   = 4;
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_ACK,
    RX_SKIP
  } rx_state_t;
endpackage

// File: rtl/bus_line_filter.sv
module bus_line_filter #(
  parameter int FILT_LEN = 4,
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  logic       meta_q, sync_q, out_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      out_q  <= 1'b1;
      run_q  <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      if (sync_q == out_q) begin
        run_q <= '0;
      end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
        out_q <= sync_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  // R10
  filt_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (out_q != $past(out_q)) |-> ($past(sync_q, 1) == out_q) && ($past(sync_q, 2) == out_q));
endmodule

// File: rtl/bus_byte_engine.sv
module bus_byte_engine
  import tune_rx_pkg::*;
#(
  parameter int DATA_MAX = 4,
  localparam int IDX_W = $clog2(DATA_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [1:0]        addr_sel,
  output logic              sda_oe,
  output logic              frame_evt,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data,
  output logic [IDX_W-1:0]  byte_idx
);
  rx_state_t         state_q;
  logic              scl_d, sda_d;
  logic [3:0]        bit_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              oe_q, stb_q, evt_q;
  logic [IDX_W-1:0]  idx_q;

  logic scl_rise, scl_fall, start_det, stop_det, addr_hit;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  assign addr_hit  = (shreg_q == {ADDR_PREFIX, addr_sel, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      bit_q   <= '0;
      shreg_q <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      stb_q   <= 1'b0;
      evt_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      stb_q <= 1'b0;
      evt_q <= start_det | stop_det;
      if (start_det) begin
        state_q <= RX_ADDR;
        bit_q   <= '0;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state_q <= RX_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          RX_ADDR, RX_DATA: begin
            if (scl_rise && bit_q < 4'd8) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_f};
              bit_q   <= bit_q + 1'b1;
            end else if (scl_fall && bit_q == 4'd8) begin
              if (state_q == RX_ADDR) begin
                if (addr_hit) begin
                  oe_q    <= 1'b1;
                  state_q <= RX_ACK;
                end else begin
                  state_q <= RX_SKIP;
                end
              end else if (cnt_q < IDX_W'(DATA_MAX)) begin
                oe_q    <= 1'b1;
                stb_q   <= 1'b1;
                idx_q   <= cnt_q;
                cnt_q   <= cnt_q + 1'b1;
                state_q <= RX_ACK;
              end else begin
                state_q <= RX_SKIP;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              bit_q   <= '0;
              state_q <= RX_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign frame_evt = evt_q;
  assign byte_stb  = stb_q;
  assign byte_data = shreg_q;
  assign byte_idx  = idx_q;

  // R2
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !scl_f);
  // R3
  skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_SKIP) |-> !oe_q && !stb_q);
  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> (idx_q < IDX_W'(DATA_MAX)));
  // R9
  evt_release_chk: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> !oe_q);
endmodule

// File: rtl/cmd_pair_sorter.sv
module cmd_pair_sorter
  import tune_rx_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(256)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_evt,
  input  logic               byte_stb,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic [IDX_W-1:0]   byte_idx,
  output logic [RATIO_W-1:0] ratio,
  output logic               ratio_upd,
  output logic [CTRL_W-1:0]  ctrl,
  output logic               ctrl_upd,
  output logic [BAND_W-1:0]  band,
  output logic               band_upd
);
  logic              have_q;
  logic [BYTE_W-1:0] first_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [BAND_W-1:0]  band_q;
  logic rupd_q, cupd_q, bupd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q  <= 1'b0;
      first_q <= '0;
      ratio_q <= RATIO_RST;
      ctrl_q  <= '0;
      band_q  <= '0;
      rupd_q  <= 1'b0;
      cupd_q  <= 1'b0;
      bupd_q  <= 1'b0;
    end else begin
      rupd_q <= 1'b0;
      cupd_q <= 1'b0;
      bupd_q <= 1'b0;
      if (frame_evt) begin
        have_q <= 1'b0;
      end else if (byte_stb) begin
        if (!have_q) begin
          first_q <= byte_data;
          have_q  <= 1'b1;
        end else begin
          have_q <= 1'b0;
          if (!first_q[BYTE_W-1]) begin
            ratio_q <= {first_q[CTRL_W-1:0], byte_data};
            rupd_q  <= 1'b1;
          end else begin
            ctrl_q <= first_q[CTRL_W-1:0];
            band_q <= byte_data[BAND_W-1:0];
            cupd_q <= 1'b1;
            bupd_q <= 1'b1;
          end
        end
      end
    end
  end

  assign ratio     = ratio_q;
  assign ratio_upd = rupd_q;
  assign ctrl      = ctrl_q;
  assign ctrl_upd  = cupd_q;
  assign band      = band_q;
  assign band_upd  = bupd_q;

  // R4
  ratio_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != $past(ratio_q)) |-> rupd_q);
  // R5
  ctrl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q != $past(ctrl_q)) || (band_q != $past(band_q))) |-> (cupd_q && bupd_q));
  // R6
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    !(rupd_q && cupd_q));
  // R7
  pair_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && have_q && !frame_evt) |-> byte_idx[0]);
endmodule

// File: rtl/tune_cmd_rx.sv
module tune_cmd_rx
  import tune_rx_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int DATA_MAX = 4,
  parameter logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(256),
  localparam int IDX_W = $clog2(DATA_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         addr_sel_i,
  output logic               sda_oe_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ratio_upd_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               ctrl_upd_o,
  output logic [BAND_W-1:0]  band_o,
  output logic               band_upd_o
);
  logic [1:0] raw_lines, clean_lines;
  logic frame_evt, byte_stb;
  logic [BYTE_W-1:0] byte_data;
  logic [IDX_W-1:0]  byte_idx;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    bus_line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst(rst), .line_i(raw_lines[g]), .line_o(clean_lines[g]));
  end

  bus_byte_engine #(.DATA_MAX(DATA_MAX)) engine_i (
    .clk(clk), .rst(rst),
    .scl_f(clean_lines[0]), .sda_f(clean_lines[1]),
    .addr_sel(addr_sel_i),
    .sda_oe(sda_oe_o), .frame_evt(frame_evt),
    .byte_stb(byte_stb), .byte_data(byte_data), .byte_idx(byte_idx));

  cmd_pair_sorter #(.IDX_W(IDX_W), .RATIO_RST(RATIO_RST)) sorter_i (
    .clk(clk), .rst(rst),
    .frame_evt(frame_evt), .byte_stb(byte_stb),
    .byte_data(byte_data), .byte_idx(byte_idx),
    .ratio(ratio_o), .ratio_upd(ratio_upd_o),
    .ctrl(ctrl_o), .ctrl_upd(ctrl_upd_o),
    .band(band_o), .band_upd(band_upd_o));
endmodule

// File: tb/tune_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module tune_cmd_rx_tb_top;
  localparam int Q = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic sda_oe;
  logic [14:0] ratio;
  logic ratio_upd, ctrl_upd, band_upd;
  logic [6:0] ctrl;
  logic [3:0] band;
  logic sda_line;

  int n_checks = 0;
  int n_fail = 0;
  int n_rupd = 0, n_cupd = 0, n_bupd = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  tune_cmd_rx dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe),
    .ratio_o(ratio), .ratio_upd_o(ratio_upd),
    .ctrl_o(ctrl), .ctrl_upd_o(ctrl_upd),
    .band_o(band), .band_upd_o(band_upd));

  always @(negedge clk) begin
    if (!rst) begin
      if (ratio_upd) n_rupd++;
      if (ctrl_upd)  n_cupd++;
      if (band_upd)  n_bupd++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  // nbits < 8 cuts the byte short; glitch_bit >= 0 puts a short clock drop in that bit
  task automatic send_bits(input logic [7:0] b, input int nbits, input int glitch_bit,
                           output bit ack);
    ack = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      sda_m = b[7-i]; wq(Q);
      scl_m = 1'b1; wq(Q);
      if (i == glitch_bit) begin
        scl_m = 1'b0; wq(2);
        scl_m = 1'b1; wq(Q - 2);
      end else begin
        wq(Q);
      end
      scl_m = 1'b0; wq(Q);
    end
    if (nbits == 8) begin
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      ack = sda_oe;
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8, -1, ack);
  endtask

  task automatic snap(output int r, output int c, output int bd,
                      output int nr, output int nc);
    r = ratio; c = ctrl; bd = band; nr = n_rupd; nc = n_cupd;
  endtask

  task automatic t_reset;
    check("R1 ratio", ratio, 256);
    check("R1 ctrl", ctrl, 0);
    check("R1 band", band, 0);
    check("R1 oe", sda_oe, 0);
    check("R1 strobes", {ratio_upd, ctrl_upd, band_upd}, 0);
  endtask

  task automatic t_addr;
    bit a;
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      bus_start;
      send_byte(8'hC0 | 8'(s << 1), a);
      check("R2 address ack", a, 1);
      bus_stop;
    end
    addr_sel = 2'd1;
  endtask

  task automatic t_mismatch;
    bit a;
    int r, c, bd, nr, nc;
    snap(r, c, bd, nr, nc);
    bus_start;
    send_byte(8'hC4, a);
    check("R3 wrong address no ack", a, 0);
    send_byte(8'h12, a);
    check("R3 data after mismatch no ack", a, 0);
    send_byte(8'h34, a);
    bus_stop;
    bus_start;
    send_byte(8'hC3, a);
    check("R3 read bit no ack", a, 0);
    send_byte(8'h12, a);
    send_byte(8'h34, a);
    bus_stop;
    check("R3 ratio unchanged", ratio, r);
    check("R3 no strobe", n_rupd + n_cupd, nr + nc);
  endtask

  task automatic t_freq;
    bit a0, a1, a2;
    int nr;
    nr = n_rupd;
    bus_start;
    send_byte(8'hC2, a0);
    send_byte(8'h5A, a1);
    send_byte(8'hC3, a2);
    bus_stop;
    check("R4 data acks", {a0, a1, a2}, 7);
    check("R4 ratio", ratio, 15'h5AC3);
    check("R4 single cycle strobe", n_rupd - nr, 1);
  endtask

  task automatic t_ctrl;
    bit a;
    int nc, nb, nr;
    nc = n_cupd; nb = n_bupd; nr = n_rupd;
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'hA5, a);
    send_byte(8'hF9, a);
    bus_stop;
    check("R5 ctrl", ctrl, 7'h25);
    check("R5 band low nibble only", band, 4'h9);
    check("R5 ctrl strobe", n_cupd - nc, 1);
    check("R5 band strobe", n_bupd - nb, 1);
    check("R5 ratio kept", ratio, 15'h5AC3);
    check("R5 no ratio strobe", n_rupd - nr, 0);
  endtask

  task automatic t_four;
    bit a;
    int nr, nc;
    nr = n_rupd; nc = n_cupd;
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'h01, a); send_byte(8'h11, a);
    send_byte(8'h8F, a); send_byte(8'h03, a);
    check("R6 fourth byte ack", a, 1);
    bus_stop;
    check("R6 freq first ratio", ratio, 15'h0111);
    check("R6 freq first ctrl", ctrl, 7'h0F);
    check("R6 freq first band", band, 4'h3);
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'hC4, a); send_byte(8'h0C, a);
    send_byte(8'h7F, a); send_byte(8'hFE, a);
    bus_stop;
    check("R6 ctrl first ctrl", ctrl, 7'h44);
    check("R6 ctrl first band", band, 4'hC);
    check("R6 ctrl first ratio", ratio, 15'h7FFE);
    check("R6 strobe counts", (n_rupd - nr) * 10 + (n_cupd - nc), 22);
  endtask

  task automatic t_three;
    bit a;
    int r, c, bd, nr, nc;
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'h22, a); send_byte(8'h33, a);
    snap(r, c, bd, nr, nc);
    send_byte(8'h81, a);
    check("R7 third byte ack", a, 1);
    bus_stop;
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'h01, a);
    bus_stop;
    check("R7 ratio from pair", ratio, 15'h2233);
    check("R7 ctrl untouched", ctrl, c);
    check("R7 no extra strobe", n_rupd + n_cupd, nr + nc);
  endtask

  task automatic t_five;
    bit a;
    int nr, nc;
    nr = n_rupd; nc = n_cupd;
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'h10, a); send_byte(8'h20, a);
    send_byte(8'h82, a); send_byte(8'h05, a);
    send_byte(8'h00, a);
    check("R8 fifth byte no ack", a, 0);
    send_byte(8'h7F, a);
    check("R8 sixth byte no ack", a, 0);
    bus_stop;
    check("R8 ratio from first four", ratio, 15'h1020);
    check("R8 ctrl from first four", ctrl, 7'h02);
    check("R8 band from first four", band, 4'h5);
    check("R8 strobe counts", (n_rupd - nr) * 10 + (n_cupd - nc), 11);
  endtask

  task automatic t_abort;
    bit a;
    int r, c, bd, nr, nc;
    snap(r, c, bd, nr, nc);
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'h44, a);
    send_bits(8'h55, 3, -1, a);
    sda_m = 1'b1; wq(Q);
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'hFF, a);
    send_bits(8'h0F, 5, -1, a);
    bus_stop;
    check("R9 ratio unchanged", ratio, r);
    check("R9 ctrl unchanged", ctrl, c);
    check("R9 band unchanged", band, bd);
    check("R9 no strobe", n_rupd + n_cupd, nr + nc);
    bus_start;
    send_byte(8'hC2, a);
    send_byte(8'h06, a); send_byte(8'h07, a);
    bus_stop;
    check("R9 clean frame after abort", ratio, 15'h0607);
  endtask

  task automatic t_glitch;
    bit a0, a1, a2;
    bus_start;
    send_byte(8'hC2, a0);
    send_bits(8'h3C, 8, 2, a1);
    send_bits(8'hA1, 8, 6, a2);
    bus_stop;
    check("R10 acks with glitches", {a0, a1, a2}, 7);
    check("R10 ratio unaffected by glitch", ratio, 15'h3CA1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wq(2);
    t_reset;
    t_addr;
    t_mismatch;
    t_freq;
    t_ctrl;
    t_four;
    t_three;
    t_five;
    t_abort;
    t_glitch;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule